// File: doc/BRIEF.md
# Flash Identification Command Decoder

This block sits in front of a byte-wide, flash-style read-only array and decides what a read returns. After reset it is in array mode and a read returns the stored byte at the given address. When a command byte is written, the address of that write plays no part. One command switches the block into identification mode. In that mode the lowest two addresses return a maker code and a part code instead of stored data. A second command switches back to array mode.

The array is a small internal ROM whose contents follow a formula set by parameters. A parameter picks the larger or smaller part variant, and that choice sets the part code. An external write-enable input guards the command path: while it is low, every write is dropped. Read data is registered. Programming, erase, status polling and locking are not part of this block.

Top module: `flash_id_cmd`

## Requirements
- R1: On reset the block enters array mode and `rdata_o` is 0x00. A reset given while identification mode is active also returns the block to array mode.
- R2: In array mode, a read at address `a` returns, one clock later, the byte `(a * ROM_STEP + ROM_BASE) mod 256`. The defaults are ROM_STEP = 29 and ROM_BASE = 71.
- R3: A write of 0x90 with `wr_en_i` high enters identification mode. The write address has no effect.
- R4: In identification mode, a read at address 0 returns 0x89.
- R5: In identification mode, a read at address 1 returns 0xAC when LARGE_PART = 1 and 0xAD when LARGE_PART = 0. The default is 1.
- R6: In identification mode, a read at any address above 1 returns 0x00. No array byte is visible at any address in this mode.
- R7: A write of 0xFF with `wr_en_i` high returns the block to array mode. The write address has no effect.
- R8: A write of any byte other than 0x90 or 0xFF leaves the mode unchanged.
- R9: While `wr_en_i` is low, writes are ignored and the mode does not change.
- R10: `rdata_o` changes only on the clock edge that samples `rd_i` high. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Command write enable; while it is low, writes are dropped |
| addr_i | input | AW | Byte address (default 4 bits) |
| wr_i | input | 1 | Write strobe for one clock |
| wdata_i | input | 8 | Command byte |
| rd_i | input | 1 | Read strobe for one clock |
| rdata_o | output | 8 | Registered read data |

## Verification
A command write changes the mode on the edge that samples it, so a read issued in the next cycle already sees the new mode. A read strobe sampled on one edge shows its byte on `rdata_o` right after that edge. The bench applies every strobe for one clock starting at a falling edge. It compares `rdata_o` at the next falling edge, half a period after the capturing edge. The hold and ignore cases are checked at the same point after stimulus that must leave the output or the mode unchanged. For the ignored writes, the unchanged mode is brought out by a following read.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
   localparam logic [7:0] CMD_ARRAY_MODE = 8'hFF;
   localparam logic [7:0] CMD_IDENT_MODE = 8'h90;
   localparam logic [7:0] MAKER_CODE     = 8'h89;
   localparam logic [7:0] PART_CODE_BIG  = 8'hAC;
   localparam logic [7:0] PART_CODE_SML  = 8'hAD;
   localparam int         BYTE_W         = 8;

   typedef enum logic {
      MODE_ARRAY = 1'b0,
      MODE_IDENT = 1'b1
   } fid_mode_e;
endpackage

// File: rtl/fid_cmd_decoder.sv
module fid_cmd_decoder
   import flash_id_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              wr_en_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output fid_mode_e         mode_o
);
   fid_mode_e mode_q, mode_d;
   logic      accept;

   assign accept = wr_i && wr_en_i;

   always_comb begin
      mode_d = mode_q;
      if (accept) begin
         case (wdata_i)
            CMD_IDENT_MODE: mode_d = MODE_IDENT;
            CMD_ARRAY_MODE: mode_d = MODE_ARRAY;
            default:        mode_d = mode_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_ARRAY;
      else        mode_q <= mode_d;
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/fid_array_rom.sv
module fid_array_rom
   import flash_id_pkg::*;
#(
   parameter int AW       = 4,
   parameter int ROM_STEP = 29,
   parameter int ROM_BASE = 71
) (
   input  logic [AW-1:0]     addr_i,
   output logic [BYTE_W-1:0] data_o
);
   localparam int DEPTH = 1 << AW;

   logic [BYTE_W-1:0] rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      localparam int CELL = (g * ROM_STEP + ROM_BASE) % 256;
      assign rom[g] = BYTE_W'(CELL);
   end

   assign data_o = rom[addr_i];
endmodule

// File: rtl/fid_id_source.sv
module fid_id_source
   import flash_id_pkg::*;
#(
   parameter int AW         = 4,
   parameter bit LARGE_PART = 1'b1
) (
   input  logic [AW-1:0]     addr_i,
   output logic [BYTE_W-1:0] id_data_o
);
   logic [BYTE_W-1:0] part_code;

   if (LARGE_PART) begin : g_big
      assign part_code = PART_CODE_BIG;
   end else begin : g_small
      assign part_code = PART_CODE_SML;
   end

   always_comb begin
      if (addr_i == AW'(0))      id_data_o = MAKER_CODE;
      else if (addr_i == AW'(1)) id_data_o = part_code;
      else                       id_data_o = '0;
   end
endmodule

// File: rtl/fid_read_port.sv
module fid_read_port
   import flash_id_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  fid_mode_e         mode_i,
   input  logic [BYTE_W-1:0] array_data_i,
   input  logic [BYTE_W-1:0] id_data_i,
   output logic [BYTE_W-1:0] rdata_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_o <= '0;
      else if (rd_i)
         rdata_o <= (mode_i == MODE_IDENT) ? id_data_i : array_data_i;
   end
endmodule

// File: rtl/flash_id_cmd.sv
module flash_id_cmd
   import flash_id_pkg::*;
#(
   parameter int AW         = 4,
   parameter bit LARGE_PART = 1'b1,
   parameter int ROM_STEP   = 29,
   parameter int ROM_BASE   = 71
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [AW-1:0]     addr_i,
   input  logic              wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic              rd_i,
   output logic [BYTE_W-1:0] rdata_o
);
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("flash_id_cmd: AW must lie in 1..12");
   end
   if (ROM_STEP < 0 || ROM_BASE < 0) begin : g_bad_rom
      $error("flash_id_cmd: ROM_STEP and ROM_BASE must be non-negative");
   end

   fid_mode_e         mode;
   logic              id_mode;
   logic [BYTE_W-1:0] array_byte;
   logic [BYTE_W-1:0] id_byte;

   fid_cmd_decoder i_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_i),
      .wr_en_i (wr_en_i),
      .wdata_i (wdata_i),
      .mode_o  (mode)
   );

   fid_array_rom #(.AW(AW), .ROM_STEP(ROM_STEP), .ROM_BASE(ROM_BASE)) i_rom (
      .addr_i (addr_i),
      .data_o (array_byte)
   );

   fid_id_source #(.AW(AW), .LARGE_PART(LARGE_PART)) i_id (
      .addr_i    (addr_i),
      .id_data_o (id_byte)
   );

   fid_read_port i_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_i         (rd_i),
      .mode_i       (mode),
      .array_data_i (array_byte),
      .id_data_i    (id_byte),
      .rdata_o      (rdata_o)
   );

   assign id_mode = (mode == MODE_IDENT);
endmodule

// File: rtl/fid_checker.sv
module fid_checker #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en_i,
   input logic [AW-1:0] addr_i,
   input logic          wr_i,
   input logic [7:0]    wdata_i,
   input logic          rd_i,
   input logic [7:0]    rdata_o,
   input logic          id_mode
);
   // R3: identification command enters identification mode
   a_r3_enter_ident: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wr_en_i && wdata_i == 8'h90) |=> id_mode);

   // R7: array command returns to array mode
   a_r7_back_to_array: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wr_en_i && wdata_i == 8'hFF) |=> !id_mode);

   // R8: other command bytes keep the mode
   a_r8_unknown_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wr_en_i && wdata_i != 8'h90 && wdata_i != 8'hFF)
      |=> id_mode == $past(id_mode));

   // R9: no accepted write, no mode change
   a_r9_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && wr_en_i) |=> id_mode == $past(id_mode));

   // R4: maker code at address 0
   a_r4_maker: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && id_mode && addr_i == AW'(0)) |=> rdata_o == 8'h89);

   // R6: zero above address 1
   a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && id_mode && addr_i > AW'(1)) |=> rdata_o == 8'h00);

   // R10: output holds without a read
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o));
endmodule

bind flash_id_cmd fid_checker #(.AW(AW)) i_fid_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en_i (wr_en_i),
   .addr_i  (addr_i),
   .wr_i    (wr_i),
   .wdata_i (wdata_i),
   .rd_i    (rd_i),
   .rdata_o (rdata_o),
   .id_mode (id_mode)
);

// File: tb/test_flash_id_cmd.sv
module test_flash_id_cmd;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 4;
   localparam int ROM_STEP   = 29;
   localparam int ROM_BASE   = 71;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          wr_i = 1'b0;
   logic [7:0]    wdata_i = '0;
   logic          rd_i = 1'b0;
   logic [7:0]    rdata_o;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_id_cmd #(.AW(AW), .LARGE_PART(1'b1), .ROM_STEP(ROM_STEP), .ROM_BASE(ROM_BASE))
   i_flash_id_cmd (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o)
   );

   // row: write?, enable, expect-array-byte?, requirement, address, data or expected byte
   typedef struct packed {
      logic       wr;
      logic       en;
      logic       rom;
      logic [3:0] req;
      logic [3:0] addr;
      logic [7:0] val;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b1,4'd2, 4'd3, 8'h00},  // R2 array read
      '{1'b0,1'b0,1'b1,4'd2, 4'd0, 8'h00},  // R2
      '{1'b0,1'b0,1'b1,4'd2, 4'd15,8'h00},  // R2 top address
      '{1'b1,1'b1,1'b0,4'd3, 4'd7, 8'h90},  // R3 enter ident at address 7
      '{1'b0,1'b0,1'b0,4'd4, 4'd0, 8'h89},  // R4
      '{1'b0,1'b0,1'b0,4'd5, 4'd1, 8'hAC},  // R5
      '{1'b0,1'b0,1'b0,4'd6, 4'd2, 8'h00},  // R6
      '{1'b0,1'b0,1'b0,4'd6, 4'd15,8'h00},  // R6
      '{1'b1,1'b1,1'b0,4'd8, 4'd0, 8'h55},  // R8 unknown byte
      '{1'b0,1'b0,1'b0,4'd8, 4'd0, 8'h89},  // R8 still ident
      '{1'b1,1'b0,1'b0,4'd9, 4'd0, 8'hFF},  // R9 guarded exit
      '{1'b0,1'b0,1'b0,4'd9, 4'd1, 8'hAC},  // R9 still ident
      '{1'b1,1'b1,1'b0,4'd7, 4'd9, 8'hFF},  // R7 exit at address 9
      '{1'b0,1'b0,1'b1,4'd7, 4'd1, 8'h00},  // R7 array again
      '{1'b0,1'b0,1'b1,4'd7, 4'd0, 8'h00},  // R7
      '{1'b1,1'b0,1'b0,4'd9, 4'd3, 8'h90},  // R9 guarded entry
      '{1'b0,1'b0,1'b1,4'd9, 4'd0, 8'h00},  // R9 still array
      '{1'b1,1'b1,1'b0,4'd8, 4'd2, 8'hA5},  // R8 unknown byte in array mode
      '{1'b0,1'b0,1'b1,4'd8, 4'd5, 8'h00},  // R8 still array
      '{1'b1,1'b1,1'b0,4'd3, 4'd0, 8'h90},  // R3 enter at address 0
      '{1'b0,1'b0,1'b0,4'd3, 4'd3, 8'h00},  // R3 ident zero fill
      '{1'b1,1'b1,1'b0,4'd7, 4'd4, 8'hFF},  // R7 exit
      '{1'b0,1'b0,1'b1,4'd7, 4'd4, 8'h00}   // R7
   };

   function automatic logic [7:0] rom_byte(input int a);
      return 8'((a * ROM_STEP + ROM_BASE) % 256);
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: rdata_o=%02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic en, input int a, input logic [7:0] d);
      @(negedge clk);
      wr_i = 1'b1; wr_en_i = en; addr_i = AW'(a); wdata_i = d;
      @(negedge clk);
      wr_i = 1'b0; wr_en_i = 1'b0;
   endtask

   task automatic do_read(input int a);
      @(negedge clk);
      rd_i = 1'b1; addr_i = AW'(a);
      @(negedge clk);
      rd_i = 1'b0;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] held;
      repeat (3) @(negedge clk);
      check("R1 reset value", rdata_o, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) begin
            do_write(VEC[i].en, int'(VEC[i].addr), VEC[i].val);
         end else begin
            do_read(int'(VEC[i].addr));
            check($sformatf("R%0d row %0d", VEC[i].req, i), rdata_o,
                  VEC[i].rom ? rom_byte(int'(VEC[i].addr)) : VEC[i].val);
         end
      end

      // R10: output holds through idle cycles and through a mode change
      do_read(6);
      held = rdata_o;
      check("R2 address 6", held, rom_byte(6));
      repeat (3) @(negedge clk);
      check("R10 idle hold", rdata_o, held);
      do_write(1'b1, 1, 8'h90);
      check("R10 hold over command write", rdata_o, held);
      @(negedge clk);
      addr_i = AW'(0);
      @(negedge clk);
      check("R10 address change without read", rdata_o, held);

      // R1: reset while identification mode is active
      do_read(0);
      check("R4 before reset", rdata_o, 8'h89);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears rdata_o", rdata_o, 8'h00);
      rst_n = 1'b1;
      do_read(0);
      check("R1 array mode after reset", rdata_o, rom_byte(0));
      do_read(1);
      check("R1 array mode after reset at address 1", rdata_o, rom_byte(1));

      summary();
      $finish;
   end
endmodule